// File: doc/BRIEF.md
# Host-to-Coprocessor Bridge Registers

This block is an 8-bit slave on a PC-style host bus. Through it the host controls a coprocessor on the same board and shares that coprocessor's memory. A small register file holds three things: the coprocessor's reset and interrupt lines, a one-byte mailbox that both sides can read and write, and a page register. The page register sets where a fixed 8 KB host aperture lands in board memory.

Host accesses to the register file finish in one cycle and never stall. A host access that falls inside the aperture is turned into a board address, built by placing the page number above the 13-bit offset. That access is latched and presented on a request port toward the shared memory. The host cycle is held off with a wait signal until the memory acknowledges. Read data is returned in the cycle the wait drops. The coprocessor side has a direct mailbox port and a strobe that clears its pending interrupt.

The reset input is asynchronous and active low. It is released through a two-stage synchroniser, so internal state leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `hcb_bridge`

## Requirements
- R1: After reset, the coprocessor reset output is high, the interrupt output is low, the mailbox holds 0x00 and the page register holds 0. A host read of the control register (register offset 0) returns 0x01.
- R2: A host write to register offset 0 copies data bit 0 into the coprocessor reset output on the next clock edge. A host read of offset 0 returns that value in bit 0.
- R3: A host write to offset 0 with data bit 1 set raises the interrupt output on the next edge. A write with bit 1 clear leaves the interrupt unchanged. A host read of offset 0 returns the interrupt in bit 1 and zeros in bits 7..2.
- R4: A one-cycle pulse on `cop_irq_clr` clears the interrupt. If a host set and a clear land in the same cycle, the interrupt ends up set.
- R5: A host write to register offset 1 stores the byte in the mailbox. The byte is visible on `cop_mbx_rdata` from the next edge and is returned by host reads of offset 1.
- R6: A coprocessor mailbox write is returned by a later host read of offset 1.
- R7: When host and coprocessor write the mailbox in the same cycle, the coprocessor's byte is kept.
- R8: Register offset 2 is the page register. It keeps the low MEM_AW-13 bits of the written byte and reads back with the upper bits zero. Offset 3 reads 0x00, and writes to it change no register.
- R9: A window access at offset O with page P issues exactly one memory request with address P*8192 + O.
- R10: During a window access, `hst_wait` stays high from the cycle the strobe is seen until the cycle after the acknowledge, which is L+2 cycles for an acknowledge latency of L. The request, its address, direction and write data stay stable until acknowledged. A read returns the acknowledged byte when the wait drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_strb | input | 1 | Host cycle strobe, held for the whole cycle |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_reg_cs | input | 1 | Host cycle targets the register file |
| hst_win_cs | input | 1 | Host cycle targets the memory aperture |
| hst_addr | input | WIN_AW | Aperture offset; bits 1..0 pick the register |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data |
| hst_wait | output | 1 | Host cycle must be extended |
| cop_reset_out | output | 1 | Holds the coprocessor in reset while high |
| cop_irq_out | output | 1 | Pending interrupt to the coprocessor |
| cop_irq_clr | input | 1 | Coprocessor clears its interrupt |
| cop_mbx_we | input | 1 | Coprocessor mailbox write strobe |
| cop_mbx_wdata | input | 8 | Coprocessor mailbox write data |
| cop_mbx_rdata | output | 8 | Mailbox contents for the coprocessor |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | MEM_AW | Board byte address |
| mem_wdata | output | 8 | Write data for the request |
| mem_rdata | input | 8 | Read data, valid with the acknowledge |
| mem_ack | input | 1 | One-cycle acknowledge |

## Verification
The bench builds the block with MEM_AW = 18 and the default 13-bit aperture, so the page register is only five bits wide. Writing 0xFF to the page register therefore shows the truncation on readback. That page also places the highest aperture offset at the very top of board memory. Window accesses are run with acknowledge latencies of 0, 1 and 3 cycles, so the wait-length rule is checked at its shortest and at longer stalls.

// File: rtl/hcb_pkg.sv
package hcb_pkg;

  // register offsets within the host register space (hst_addr[1:0])
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_MBOX = 2'd1,
    REG_PAGE = 2'd2,
    REG_NONE = 2'd3
  } hcb_reg_e;

  localparam int CTRL_RST_BIT = 0;
  localparam int CTRL_IRQ_BIT = 1;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_BUSY = 2'd1,
    WIN_DONE = 2'd2
  } win_state_e;

endpackage

// File: rtl/hcb_regs.sv
module hcb_regs #(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cop_mbx_we,
  input  logic [7:0]        cop_mbx_wdata,
  input  logic              cop_irq_clr,
  output logic              cop_rst,
  output logic              cop_irq,
  output logic [7:0]        mbx,
  output logic [PAGE_W-1:0] page
);
  import hcb_pkg::*;

  logic              rst_q, rst_d, rst_en;
  logic              irq_q, irq_d, irq_en;
  logic [7:0]        mbx_q, mbx_d;
  logic              mbx_en;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              page_en;
  logic              ctrl_wr, mbox_wr, page_wr, irq_set;
  hcb_reg_e          sel;

  assign sel = hcb_reg_e'(reg_sel);

  always_comb begin
    ctrl_wr = reg_wr && (sel == REG_CTRL);
    mbox_wr = reg_wr && (sel == REG_MBOX);
    page_wr = reg_wr && (sel == REG_PAGE);

    rst_en  = ctrl_wr;
    rst_d   = reg_wdata[CTRL_RST_BIT];

    irq_set = ctrl_wr && reg_wdata[CTRL_IRQ_BIT];
    irq_en  = irq_set || cop_irq_clr;
    irq_d   = irq_set;                 // a set in the same cycle beats a clear

    mbx_en  = mbox_wr || cop_mbx_we;
    mbx_d   = cop_mbx_we ? cop_mbx_wdata : reg_wdata;  // coprocessor wins

    page_en = page_wr;
    page_d  = reg_wdata[PAGE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b1;
      irq_q  <= 1'b0;
      mbx_q  <= '0;
      page_q <= '0;
    end else begin
      if (rst_en)  rst_q  <= rst_d;
      if (irq_en)  irq_q  <= irq_d;
      if (mbx_en)  mbx_q  <= mbx_d;
      if (page_en) page_q <= page_d;
    end
  end

  always_comb begin
    unique case (sel)
      REG_CTRL: reg_rdata = {6'b0, irq_q, rst_q};
      REG_MBOX: reg_rdata = mbx_q;
      REG_PAGE: reg_rdata = 8'(page_q);
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign cop_rst = rst_q;
  assign cop_irq = irq_q;
  assign mbx     = mbx_q;
  assign page    = page_q;

  AST_RST_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0) |=> (cop_rst == $past(reg_wdata[0])));  // R2

  AST_IRQ_RISE_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cop_irq) |-> $past(reg_wr && reg_sel == 2'd0 && reg_wdata[1]));  // R3

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_irq_clr && !(reg_wr && reg_sel == 2'd0 && reg_wdata[1])) |=> !cop_irq);  // R4

  AST_COP_MBX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cop_mbx_we |=> (mbx == $past(cop_mbx_wdata)));  // R7

  AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3 && !cop_mbx_we && !cop_irq_clr)
      |=> ($stable(cop_rst) && $stable(cop_irq) && $stable(mbx) && $stable(page)));  // R8

endmodule

// File: rtl/hcb_win.sv
module hcb_win #(
  parameter int MEM_AW = 20,
  parameter int WIN_AW = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc,
  input  logic                     acc_we,
  input  logic [WIN_AW-1:0]        acc_offs,
  input  logic [7:0]               acc_wdata,
  input  logic [MEM_AW-WIN_AW-1:0] page,
  output logic                     host_wait,
  output logic [7:0]               host_rdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [MEM_AW-1:0]        mem_addr,
  output logic [7:0]               mem_wdata,
  input  logic [7:0]               mem_rdata,
  input  logic                     mem_ack
);
  import hcb_pkg::*;

  localparam int PAGE_W = MEM_AW - WIN_AW;

  win_state_e        state_q, state_d;
  logic [MEM_AW-1:0] addr_q, addr_d;
  logic              we_q;
  logic [7:0]        wdata_q, rdata_q;
  logic              cap_en, rd_en;

  // board address: page number above the aperture offset
  assign addr_d = {page[PAGE_W-1:0], acc_offs};

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    rd_en   = 1'b0;
    unique case (state_q)
      WIN_IDLE: if (acc) begin
        state_d = WIN_BUSY;
        cap_en  = 1'b1;
      end
      WIN_BUSY: if (mem_ack) begin
        state_d = WIN_DONE;
        rd_en   = 1'b1;
      end
      WIN_DONE: if (!acc) state_d = WIN_IDLE;
      default:  state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        addr_q  <= addr_d;
        we_q    <= acc_we;
        wdata_q <= acc_wdata;
      end
      if (rd_en) rdata_q <= mem_rdata;
    end
  end

  assign mem_req    = (state_q == WIN_BUSY);
  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign host_wait  = acc && (state_q != WIN_DONE);
  assign host_rdata = rdata_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));  // R10

  AST_WAIT_ENDS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(host_wait) && acc) |-> $past(mem_ack));  // R10

endmodule

// File: rtl/hcb_bridge.sv
module hcb_bridge #(
  parameter int MEM_AW = 20,
  parameter int WIN_AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_strb,
  input  logic              hst_we,
  input  logic              hst_reg_cs,
  input  logic              hst_win_cs,
  input  logic [WIN_AW-1:0] hst_addr,
  input  logic [7:0]        hst_wdata,
  output logic [7:0]        hst_rdata,
  output logic              hst_wait,
  output logic              cop_reset_out,
  output logic              cop_irq_out,
  input  logic              cop_irq_clr,
  input  logic              cop_mbx_we,
  input  logic [7:0]        cop_mbx_wdata,
  output logic [7:0]        cop_mbx_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack
);

  localparam int PAGE_W = MEM_AW - WIN_AW;

  logic              rst_meta_q, rst_sync_q;
  logic              reg_wr, win_acc;
  logic [7:0]        reg_rdata, win_rdata;
  logic [PAGE_W-1:0] page;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign reg_wr  = hst_strb && hst_reg_cs && hst_we;
  assign win_acc = hst_strb && hst_win_cs;

  hcb_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .reg_wr        (reg_wr),
    .reg_sel       (hst_addr[1:0]),
    .reg_wdata     (hst_wdata),
    .reg_rdata     (reg_rdata),
    .cop_mbx_we    (cop_mbx_we),
    .cop_mbx_wdata (cop_mbx_wdata),
    .cop_irq_clr   (cop_irq_clr),
    .cop_rst       (cop_reset_out),
    .cop_irq       (cop_irq_out),
    .mbx           (cop_mbx_rdata),
    .page          (page)
  );

  hcb_win #(.MEM_AW(MEM_AW), .WIN_AW(WIN_AW)) u_win (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .acc        (win_acc),
    .acc_we     (hst_we),
    .acc_offs   (hst_addr),
    .acc_wdata  (hst_wdata),
    .page       (page),
    .host_wait  (hst_wait),
    .host_rdata (win_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack)
  );

  assign hst_rdata = hst_reg_cs ? reg_rdata : win_rdata;

endmodule

// File: tb/test_hcb_bridge.sv
`timescale 1ns/1ps
module test_hcb_bridge;
  localparam int MEM_AW = 18;
  localparam int WIN_AW = 13;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              hst_strb, hst_we, hst_reg_cs, hst_win_cs;
  logic [WIN_AW-1:0] hst_addr;
  logic [7:0]        hst_wdata, hst_rdata;
  logic              hst_wait;
  logic              cop_reset_out, cop_irq_out, cop_irq_clr, cop_mbx_we;
  logic [7:0]        cop_mbx_wdata, cop_mbx_rdata;
  logic              mem_req, mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0]        mem_wdata;
  logic [7:0]        mem_rdata = 8'h00;
  logic              mem_ack = 1'b0;

  always #4 clk = ~clk;

  hcb_bridge #(.MEM_AW(MEM_AW), .WIN_AW(WIN_AW)) i_hcb_bridge (.*);

  typedef struct packed {
    logic [MEM_AW-1:0] addr;
    logic              we;
    logic [7:0]        wdata;
  } item_t;

  item_t expq[$];
  int    n_chk = 0, n_fail = 0, mem_lat = 0, lat_cnt = 0;
  bit    done = 1'b0;

  function automatic logic [7:0] pat(input logic [MEM_AW-1:0] a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'(a >> 16) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (lat_cnt == mem_lat) begin
        if (expq.size() == 0) chk("R9 unexpected request", 32'(mem_addr), 32'hFFFFFFFF);
        else begin
          item_t e;
          e = expq.pop_front();
          chk("R9 board address", 32'(mem_addr), 32'(e.addr));
          chk("R10 direction", 32'(mem_we), 32'(e.we));
          if (e.we) chk("R10 write data", 32'(mem_wdata), 32'(e.wdata));
        end
        mem_rdata <= pat(mem_addr);
        mem_ack   <= 1'b1;
        lat_cnt   <= 0;
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  task automatic reg_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    hst_strb = 1; hst_reg_cs = 1; hst_we = 1; hst_addr = WIN_AW'(sel); hst_wdata = d;
    @(negedge clk);
    hst_strb = 0; hst_reg_cs = 0; hst_we = 0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, input logic [7:0] exp, input string req);
    @(negedge clk);
    hst_strb = 1; hst_reg_cs = 1; hst_we = 0; hst_addr = WIN_AW'(sel);
    #1;
    chk(req, 32'(hst_rdata), 32'(exp));
    chk({req, " no wait"}, 32'(hst_wait), 32'd0);
    @(negedge clk);
    hst_strb = 0; hst_reg_cs = 0;
  endtask

  task automatic win_acc(input logic we, input logic [WIN_AW-1:0] off, input logic [7:0] wd,
                         input int lat, input logic [MEM_AW-WIN_AW-1:0] pg);
    logic [MEM_AW-1:0] ea;
    int waits;
    ea = {pg, off};
    waits = 0;
    mem_lat = lat;
    expq.push_back('{ea, we, wd});
    @(negedge clk);
    hst_strb = 1; hst_win_cs = 1; hst_we = we; hst_addr = off; hst_wdata = wd;
    #1;
    while (hst_wait && waits < 50) begin
      waits++;
      @(negedge clk);
      #1;
    end
    chk("R10 wait length", 32'(waits), 32'(lat + 2));
    if (!we) chk("R10 read data", 32'(hst_rdata), 32'(pat(ea)));
    hst_strb = 0; hst_win_cs = 0; hst_we = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; hst_strb = 0; hst_we = 0; hst_reg_cs = 0; hst_win_cs = 0;
    hst_addr = '0; hst_wdata = '0; cop_irq_clr = 0; cop_mbx_we = 0; cop_mbx_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 reset out", 32'(cop_reset_out), 32'd1);
    chk("R1 irq out", 32'(cop_irq_out), 32'd0);
    chk("R1 mailbox", 32'(cop_mbx_rdata), 32'd0);
    chk("R1 mem_req idle", 32'(mem_req), 32'd0);
    reg_rd(2'd0, 8'h01, "R1 ctrl read");
    reg_rd(2'd2, 8'h00, "R1 page read");

    // R2 reset control
    reg_wr(2'd0, 8'h00);
    chk("R2 reset released", 32'(cop_reset_out), 32'd0);
    reg_rd(2'd0, 8'h00, "R2 ctrl read");

    // R3 interrupt set, write of zero leaves it
    reg_wr(2'd0, 8'h02);
    chk("R3 irq raised", 32'(cop_irq_out), 32'd1);
    reg_wr(2'd0, 8'h00);
    chk("R3 irq kept", 32'(cop_irq_out), 32'd1);
    reg_rd(2'd0, 8'h02, "R3 ctrl read");

    // R4 clear, and set beats clear
    @(negedge clk); cop_irq_clr = 1;
    @(negedge clk); cop_irq_clr = 0;
    chk("R4 irq cleared", 32'(cop_irq_out), 32'd0);
    @(negedge clk);
    hst_strb = 1; hst_reg_cs = 1; hst_we = 1; hst_addr = '0; hst_wdata = 8'h02; cop_irq_clr = 1;
    @(negedge clk);
    hst_strb = 0; hst_reg_cs = 0; hst_we = 0; cop_irq_clr = 0;
    chk("R4 set wins", 32'(cop_irq_out), 32'd1);
    @(negedge clk); cop_irq_clr = 1;
    @(negedge clk); cop_irq_clr = 0;
    reg_wr(2'd0, 8'h01);
    chk("R2 reset reasserted", 32'(cop_reset_out), 32'd1);

    // R5 host mailbox write
    reg_wr(2'd1, 8'hA5);
    chk("R5 cop sees mailbox", 32'(cop_mbx_rdata), 32'hA5);
    reg_rd(2'd1, 8'hA5, "R5 host reads mailbox");

    // R6 coprocessor write
    @(negedge clk); cop_mbx_we = 1; cop_mbx_wdata = 8'h3C;
    @(negedge clk); cop_mbx_we = 0;
    reg_rd(2'd1, 8'h3C, "R6 host reads cop byte");

    // R7 collision
    @(negedge clk);
    hst_strb = 1; hst_reg_cs = 1; hst_we = 1; hst_addr = WIN_AW'(1); hst_wdata = 8'h11;
    cop_mbx_we = 1; cop_mbx_wdata = 8'h22;
    @(negedge clk);
    hst_strb = 0; hst_reg_cs = 0; hst_we = 0; cop_mbx_we = 0;
    chk("R7 cop wins", 32'(cop_mbx_rdata), 32'h22);

    // R8 page truncation and spare offset
    reg_wr(2'd2, 8'hFF);
    reg_rd(2'd2, 8'h1F, "R8 page readback");
    reg_wr(2'd3, 8'h55);
    reg_rd(2'd3, 8'h00, "R8 spare reads zero");
    reg_rd(2'd0, 8'h01, "R8 ctrl untouched");
    reg_rd(2'd1, 8'h22, "R8 mailbox untouched");
    reg_rd(2'd2, 8'h1F, "R8 page untouched");

    // R9 / R10 window accesses
    win_acc(1'b0, 13'h1FFF, 8'h00, 0, 5'h1F);
    win_acc(1'b1, 13'h0000, 8'hC3, 1, 5'h1F);
    win_acc(1'b0, 13'h1234, 8'h00, 3, 5'h1F);
    reg_wr(2'd2, 8'h00);
    win_acc(1'b0, 13'h0ABC, 8'h00, 1, 5'h00);
    reg_wr(2'd2, 8'h0A);
    win_acc(1'b1, 13'h0777, 8'h96, 3, 5'h0A);
    win_acc(1'b0, 13'h0001, 8'h00, 0, 5'h0A);
    repeat (3) @(negedge clk);
    chk("R9 all requests seen", 32'(expq.size()), 32'd0);
    chk("R9 no stray request", 32'(mem_req), 32'd0);

    finish_run();
  end
endmodule